// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block owns the program-counter pair of a processor core and the control state that changes when the core is diverted into a handler. It keeps a current PC and a next PC, so a delayed branch can run one more instruction, the slot instruction, before the target takes effect. Each cycle the surrounding core reports what happened to the instruction: it completed, it was a delayed branch, it wrote the status word or the vector base, or it raised an exception. Separately, an interrupt source may request entry.

When an event is taken, the block saves the status word, a return PC and the stack pointer (R15) into shadow registers. It records the event code and forces the status word into privileged mode, with further events blocked and the alternate register bank selected. It then vectors to the vector base plus an offset. For an exception the offset comes with the request; for an interrupt it is fixed. Whenever the register-bank bit of the status word changes, the block pulses a bank-swap output one cycle later. The register file uses that pulse to exchange R0 to R7 with their banked copies. Instruction decode, memory and interrupt prioritisation sit outside the block.

Top module: `exc_entry_ctrl`

## Requirements
- R1: In reset the outputs hold these values: PC 0xA0000000, next PC 0xA0000002, status word 0x700000F0, vector base 0, FP status word 0x00040001, slot flag 0. Every other register output is 0.
- R2: A completed instruction (`step`) with no event and no branch loads PC from next PC, adds 2 to next PC and clears the slot flag.
- R3: A delayed branch (`br_req`) with no event sets the slot flag, loads PC from next PC and loads next PC from `br_target`. It takes precedence over `step`.
- R4: When an exception is taken, `ssr` gets the old status word, `spc` gets old PC + 2, `sgr` gets `r15` and `expevt` gets the code. PC becomes vector base + zero-extended offset, next PC becomes PC + 2, and the slot flag clears.
- R5: On any taken event, the new status word is the old one with bits 30 (privileged), 29 (register bank) and 28 (block events) set.
- R6: An exception request with code 0x180 (illegal instruction) that arrives while the slot flag is set is recorded as code 0x1A0 (illegal in slot). Other codes (trap 0x160, FPU disabled 0x800) pass unchanged.
- R7: When an interrupt is taken, `intevt` gets `irq_code`, `spc` gets the old PC, PC becomes vector base + 0x600, and next PC becomes that + 2. `expevt` does not change.
- R8: An interrupt request has no effect while status bit 28 is set or the slot flag is set. In that cycle the step, branch and write inputs act as if no interrupt had been requested.
- R9: An exception request beats an interrupt request in the same cycle. A taken event overrides `step`, `br_req`, `sr_wr` and `vbr_wr` in that cycle.
- R10: A taken exception with code 0x160 (trap) loads `trap_imm` into `tra`. No other event changes `tra`.
- R11: `bank_swap` is high for exactly the cycle after a status-word update that changed bit 29, and low otherwise.
- R12: When no event is taken, `sr_wr` loads `sr_wdata` into the status word and `vbr_wr` loads `vbr_wdata` into the vector base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_req | input | 1 | Current instruction raises an exception |
| exc_code | input | 12 | Exception event code |
| exc_off | input | 12 | Exception vector offset |
| trap_imm | input | 8 | Trap immediate |
| irq_req | input | 1 | Interrupt pending before next fetch |
| irq_code | input | 12 | Interrupt event code |
| step | input | 1 | Instruction completed normally |
| br_req | input | 1 | Instruction is a delayed branch |
| br_target | input | 32 | Branch target |
| sr_wr | input | 1 | Status-word write |
| sr_wdata | input | 32 | Status-word write data |
| vbr_wr | input | 1 | Vector-base write |
| vbr_wdata | input | 32 | Vector-base write data |
| r15 | input | 32 | Current stack pointer |
| pc | output | 32 | Current PC |
| npc | output | 32 | Next PC |
| in_slot | output | 1 | Current instruction is a delay slot |
| sr | output | 32 | Status word |
| ssr | output | 32 | Saved status word |
| spc | output | 32 | Saved return PC |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Last exception code |
| intevt | output | 12 | Last interrupt code |
| tra | output | 8 | Last trap immediate |
| vbr | output | 32 | Vector base |
| fpscr | output | 32 | FP status word |
| bank_swap | output | 1 | Swap R0-R7 with banked copies |

## Verification
The assertions check on every cycle that a taken event lands on the right vector with next PC two bytes ahead. They also check that the entry forces the three control bits, that the old status word reaches the shadow, that a branch moves next PC into PC with the slot flag set, that no interrupt enters while blocked or in a slot, and that `bank_swap` only follows a real bank-bit change. Only the bench scenarios show the remaining behaviour. That covers the recoding of an illegal instruction in a slot, the trap immediate capture, exception-over-interrupt priority, and the return PCs that differ between exception (+2) and interrupt. It also covers a deferred interrupt that is taken later once the block bit clears.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the entry controller.
// Assumes a 32-bit status word with control bits at positions 28..30.
package exc_entry_pkg;
    localparam int SR_BL_BIT = 28;
    localparam int SR_RB_BIT = 29;
    localparam int SR_MD_BIT = 30;

    localparam logic [11:0] CODE_ILLEGAL      = 12'h180;
    localparam logic [11:0] CODE_SLOT_ILLEGAL = 12'h1A0;
    localparam logic [11:0] CODE_TRAP         = 12'h160;
    localparam logic [11:0] IRQ_OFFSET        = 12'h600;

    localparam logic [31:0] PC_RESET    = 32'hA000_0000;
    localparam logic [31:0] SR_RESET    = 32'h7000_00F0;
    localparam logic [31:0] FPSCR_RESET = 32'h0004_0001;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_kind_t;
endpackage

// File: rtl/exc_entry_sel.sv
// Chooses which event, if any, is taken this cycle and the code/offset to use.
// Assumes the exception request is already qualified by the core.
module exc_entry_sel
    import exc_entry_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_off,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              in_slot,
    input  logic              sr_bl,
    output ev_kind_t          kind,
    output logic [CODE_W-1:0] ev_code,
    output logic [CODE_W-1:0] ev_off
);
    // Exception first, then an unblocked interrupt outside a delay slot.
    always_comb begin
        kind    = EV_NONE;
        ev_code = exc_code;
        ev_off  = exc_off;
        if (exc_req) begin
            kind = EV_EXC;
            if (exc_code == CODE_W'(CODE_ILLEGAL) && in_slot)
                ev_code = CODE_W'(CODE_SLOT_ILLEGAL);
        end else if (irq_req && !in_slot && !sr_bl) begin
            kind    = EV_IRQ;
            ev_code = irq_code;
            ev_off  = CODE_W'(IRQ_OFFSET);
        end
    end
endmodule

// File: rtl/exc_pc_seq.sv
// Current/next PC pair with delay-slot flag.
// Assumes at most one of entry, branch, step acts; entry wins, then branch.
module exc_pc_seq
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter,
    input  logic [DATA_W-1:0] enter_pc,
    input  logic              br_req,
    input  logic [DATA_W-1:0] br_target,
    input  logic              step,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] npc,
    output logic              in_slot
);
    localparam logic [DATA_W-1:0] INSN_BYTES = DATA_W'(2);

    // Advance, branch or vector the PC pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc      <= DATA_W'(PC_RESET);
            npc     <= DATA_W'(PC_RESET) + INSN_BYTES;
            in_slot <= 1'b0;
        end else if (enter) begin
            pc      <= enter_pc;
            npc     <= enter_pc + INSN_BYTES;
            in_slot <= 1'b0;
        end else if (br_req) begin
            pc      <= npc;
            npc     <= br_target;
            in_slot <= 1'b1;
        end else if (step) begin
            pc      <= npc;
            npc     <= npc + INSN_BYTES;
            in_slot <= 1'b0;
        end
    end

    // R3
    branch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_req && !enter) |=> (in_slot && pc == $past(npc)));
endmodule

// File: rtl/exc_ctl_regs.sv
// Status word, shadows, event codes, vector base and bank-swap pulse.
// Assumes kind comes from exc_entry_sel in the same cycle.
module exc_ctl_regs
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ev_kind_t          kind,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] r15,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              vbr_wr,
    input  logic [DATA_W-1:0] vbr_wdata,
    output logic [DATA_W-1:0] sr,
    output logic [DATA_W-1:0] ssr,
    output logic [DATA_W-1:0] spc,
    output logic [DATA_W-1:0] sgr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [IMM_W-1:0]  tra,
    output logic [DATA_W-1:0] vbr,
    output logic [DATA_W-1:0] fpscr,
    output logic              bank_swap
);
    localparam logic [DATA_W-1:0] ENTRY_MASK = (DATA_W'(1) << SR_MD_BIT) |
                                               (DATA_W'(1) << SR_RB_BIT) |
                                               (DATA_W'(1) << SR_BL_BIT);
    localparam logic [DATA_W-1:0] EXC_RET_ADJ = DATA_W'(2);

    logic [DATA_W-1:0] sr_next;
    logic              entering;

    assign entering = (kind != EV_NONE);

    // Next status word: forced bits on entry, else software write.
    always_comb begin
        sr_next = sr;
        if (entering)   sr_next = sr | ENTRY_MASK;
        else if (sr_wr) sr_next = sr_wdata;
    end

    // Status word and bank-change pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr        <= DATA_W'(SR_RESET);
            bank_swap <= 1'b0;
        end else begin
            sr        <= sr_next;
            bank_swap <= sr_next[SR_RB_BIT] ^ sr[SR_RB_BIT];
        end
    end

    // Shadow copies and event codes captured on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssr    <= '0;
            spc    <= '0;
            sgr    <= '0;
            expevt <= '0;
            intevt <= '0;
            tra    <= '0;
        end else if (entering) begin
            ssr <= sr;
            sgr <= r15;
            if (kind == EV_EXC) begin
                spc    <= pc + EXC_RET_ADJ;
                expevt <= ev_code;
                if (ev_code == CODE_W'(CODE_TRAP)) tra <= trap_imm;
            end else begin
                spc    <= pc;
                intevt <= ev_code;
            end
        end
    end

    // Vector base and FP status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbr   <= '0;
            fpscr <= DATA_W'(FPSCR_RESET);
        end else if (!entering && vbr_wr) begin
            vbr <= vbr_wdata;
        end
    end

    // R5
    entry_sr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != EV_NONE) |=> (sr[SR_MD_BIT] && sr[SR_RB_BIT] && sr[SR_BL_BIT]));
    // R4
    shadow_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != EV_NONE) |=> (ssr == $past(sr)));
    // R11
    bank_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_swap |-> (sr[SR_RB_BIT] != $past(sr[SR_RB_BIT])));
endmodule

// File: rtl/exc_entry_ctrl.sv
// Top of the exception/interrupt entry controller: selects the event,
// drives the PC pair and the control registers. Assumes one instruction
// outcome per cycle from the core.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CODE_W = 12,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CODE_W-1:0] exc_off,
    input  logic [IMM_W-1:0]  trap_imm,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              step,
    input  logic              br_req,
    input  logic [DATA_W-1:0] br_target,
    input  logic              sr_wr,
    input  logic [DATA_W-1:0] sr_wdata,
    input  logic              vbr_wr,
    input  logic [DATA_W-1:0] vbr_wdata,
    input  logic [DATA_W-1:0] r15,
    output logic [DATA_W-1:0] pc,
    output logic [DATA_W-1:0] npc,
    output logic              in_slot,
    output logic [DATA_W-1:0] sr,
    output logic [DATA_W-1:0] ssr,
    output logic [DATA_W-1:0] spc,
    output logic [DATA_W-1:0] sgr,
    output logic [CODE_W-1:0] expevt,
    output logic [CODE_W-1:0] intevt,
    output logic [IMM_W-1:0]  tra,
    output logic [DATA_W-1:0] vbr,
    output logic [DATA_W-1:0] fpscr,
    output logic              bank_swap
);
    ev_kind_t          kind;
    logic [CODE_W-1:0] ev_code;
    logic [CODE_W-1:0] ev_off;
    logic [DATA_W-1:0] enter_pc;

    exc_entry_sel #(.CODE_W(CODE_W)) u_sel (
        .exc_req (exc_req),
        .exc_code(exc_code),
        .exc_off (exc_off),
        .irq_req (irq_req),
        .irq_code(irq_code),
        .in_slot (in_slot),
        .sr_bl   (sr[SR_BL_BIT]),
        .kind    (kind),
        .ev_code (ev_code),
        .ev_off  (ev_off)
    );

    // Handler address: base plus zero-extended offset.
    assign enter_pc = vbr + DATA_W'(ev_off);

    exc_pc_seq #(.DATA_W(DATA_W)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (kind != EV_NONE),
        .enter_pc (enter_pc),
        .br_req   (br_req),
        .br_target(br_target),
        .step     (step),
        .pc       (pc),
        .npc      (npc),
        .in_slot  (in_slot)
    );

    exc_ctl_regs #(.DATA_W(DATA_W), .CODE_W(CODE_W), .IMM_W(IMM_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .kind     (kind),
        .ev_code  (ev_code),
        .trap_imm (trap_imm),
        .pc       (pc),
        .r15      (r15),
        .sr_wr    (sr_wr),
        .sr_wdata (sr_wdata),
        .vbr_wr   (vbr_wr),
        .vbr_wdata(vbr_wdata),
        .sr       (sr),
        .ssr      (ssr),
        .spc      (spc),
        .sgr      (sgr),
        .expevt   (expevt),
        .intevt   (intevt),
        .tra      (tra),
        .vbr      (vbr),
        .fpscr    (fpscr),
        .bank_swap(bank_swap)
    );

    // R4
    exc_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_req) |=> (pc == $past(vbr) + DATA_W'($past(exc_off)) && npc == pc + DATA_W'(2)));
    // R7
    irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == EV_IRQ) |=> (pc == $past(vbr) + DATA_W'(IRQ_OFFSET) && !in_slot));
    // R8
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr[SR_BL_BIT] || in_slot) |-> (kind != EV_IRQ));
endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_req = 0, irq_req = 0, step = 0, br_req = 0, sr_wr = 0, vbr_wr = 0;
    logic [11:0] exc_code = 0, exc_off = 0, irq_code = 0;
    logic [7:0]  trap_imm = 0;
    logic [31:0] br_target = 0, sr_wdata = 0, vbr_wdata = 0, r15 = 0;
    logic [31:0] pc, npc, sr, ssr, spc, sgr, vbr, fpscr;
    logic [11:0] expevt, intevt;
    logic [7:0]  tra;
    logic        in_slot, bank_swap;

    int n_chk = 0, n_fail = 0;

    // model state
    logic [31:0] m_pc = 32'hA000_0000, m_npc = 32'hA000_0002, m_sr = 32'h7000_00F0;
    logic [31:0] m_ssr = 0, m_spc = 0, m_sgr = 0, m_vbr = 0;
    logic [11:0] m_expevt = 0, m_intevt = 0;
    logic [7:0]  m_tra = 0;
    logic        m_slot = 0, m_swap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_code(exc_code),
        .exc_off(exc_off), .trap_imm(trap_imm), .irq_req(irq_req),
        .irq_code(irq_code), .step(step), .br_req(br_req), .br_target(br_target),
        .sr_wr(sr_wr), .sr_wdata(sr_wdata), .vbr_wr(vbr_wr), .vbr_wdata(vbr_wdata),
        .r15(r15), .pc(pc), .npc(npc), .in_slot(in_slot), .sr(sr), .ssr(ssr),
        .spc(spc), .sgr(sgr), .expevt(expevt), .intevt(intevt), .tra(tra),
        .vbr(vbr), .fpscr(fpscr), .bank_swap(bank_swap)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [11:0] eff_code(input logic [11:0] c, input logic slot);
        return (c == 12'h180 && slot) ? 12'h1A0 : c;
    endfunction

    // One clock: update model from driven inputs, then compare at negedge.
    task automatic run_cycle();
        string       tag;
        logic [31:0] nsr;
        logic        take_irq, entered;
        logic [11:0] c;
        nsr = m_sr;
        entered = 0;
        take_irq = irq_req && !m_slot && !m_sr[28];
        c = eff_code(exc_code, m_slot);
        if (exc_req && irq_req)             tag = "R9";
        else if (exc_req && c != exc_code)  tag = "R6";
        else if (exc_req && c == 12'h160)   tag = "R10";
        else if (exc_req)                   tag = "R4";
        else if (take_irq)                  tag = "R7";
        else if (irq_req)                   tag = "R8";
        else if (br_req)                    tag = "R3";
        else if (step)                      tag = "R2";
        else                                tag = "R12";
        if (exc_req) begin
            entered = 1;
            m_ssr = m_sr; m_spc = m_pc + 2; m_sgr = r15; m_expevt = c;
            if (c == 12'h160) m_tra = trap_imm;
            nsr = m_sr | 32'h7000_0000;
            m_pc = m_vbr + {20'd0, exc_off}; m_npc = m_pc + 2; m_slot = 0;
        end else if (take_irq) begin
            entered = 1;
            m_ssr = m_sr; m_spc = m_pc; m_sgr = r15; m_intevt = irq_code;
            nsr = m_sr | 32'h7000_0000;
            m_pc = m_vbr + 32'h600; m_npc = m_pc + 2; m_slot = 0;
        end else begin
            if (br_req) begin
                m_pc = m_npc; m_npc = br_target; m_slot = 1;
            end else if (step) begin
                m_pc = m_npc; m_npc = m_npc + 2; m_slot = 0;
            end
            if (sr_wr)  nsr = sr_wdata;
            if (vbr_wr) m_vbr = vbr_wdata;
        end
        m_swap = nsr[29] ^ m_sr[29];
        m_sr = nsr;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "pc", pc, m_pc);
        chk(tag, "npc", npc, m_npc);
        chk(tag, "in_slot", {31'd0, in_slot}, {31'd0, m_slot});
        chk(entered ? "R5" : tag, "sr", sr, m_sr);
        chk(tag, "ssr", ssr, m_ssr);
        chk(tag, "spc", spc, m_spc);
        chk(tag, "sgr", sgr, m_sgr);
        chk(tag, "expevt", {20'd0, expevt}, {20'd0, m_expevt});
        chk(tag, "intevt", {20'd0, intevt}, {20'd0, m_intevt});
        chk("R10", "tra", {24'd0, tra}, {24'd0, m_tra});
        chk("R12", "vbr", vbr, m_vbr);
        chk("R11", "bank_swap", {31'd0, bank_swap}, {31'd0, m_swap});
        exc_req = 0; irq_req = 0; step = 0; br_req = 0; sr_wr = 0; vbr_wr = 0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "pc", pc, 32'hA000_0000);
        chk("R1", "npc", npc, 32'hA000_0002);
        chk("R1", "sr", sr, 32'h7000_00F0);
        chk("R1", "vbr", vbr, 32'd0);
        chk("R1", "fpscr", fpscr, 32'h0004_0001);
        chk("R1", "slot", {31'd0, in_slot}, 32'd0);
        rst_n = 1'b1;

        // R12: vector base write
        vbr_wr = 1; vbr_wdata = 32'h8C00_0000; run_cycle();
        // R8: interrupt blocked by status bit 28
        irq_req = 1; irq_code = 12'h3C0; step = 1; run_cycle();
        // R11/R12: clear control bits, bank bit flips
        sr_wr = 1; sr_wdata = 32'h0000_00F0; run_cycle();
        // R7: interrupt taken
        irq_req = 1; irq_code = 12'h3C0; r15 = 32'h1234_5678; run_cycle();
        sr_wr = 1; sr_wdata = 32'h0; run_cycle();
        // R3 then R6: illegal in slot recoded
        br_req = 1; br_target = 32'h8C01_0000; run_cycle();
        exc_req = 1; exc_code = 12'h180; exc_off = 12'h100; run_cycle();
        sr_wr = 1; sr_wdata = 32'h0; run_cycle();
        // R8: interrupt deferred in slot
        br_req = 1; br_target = 32'h8C02_0000; run_cycle();
        irq_req = 1; irq_code = 12'h200; step = 1; run_cycle();
        // R9: exception beats interrupt and step
        exc_req = 1; exc_code = 12'h800; exc_off = 12'h100;
        irq_req = 1; irq_code = 12'h220; step = 1; sr_wr = 1; sr_wdata = 0; run_cycle();
        // R10: trap immediate captured
        exc_req = 1; exc_code = 12'h160; exc_off = 12'h100; trap_imm = 8'h5A; run_cycle();
        // R2: plain steps
        step = 1; run_cycle();
        step = 1; run_cycle();

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            r15 = $urandom();
            trap_imm = 8'($urandom());
            if (r < 8) begin
                exc_req = 1;
                case ($urandom_range(0, 3))
                    0: exc_code = 12'h180;
                    1: exc_code = 12'h1A0;
                    2: exc_code = 12'h160;
                    default: exc_code = 12'h800;
                endcase
                exc_off = 12'h100;
            end
            if ($urandom_range(0, 99) < 15) begin
                irq_req = 1; irq_code = 12'($urandom_range(0, 4095));
            end
            if (r >= 8 && r < 30) begin
                br_req = 1; br_target = {$urandom(), 1'b0} & 32'hFFFF_FFFE;
            end
            if ($urandom_range(0, 99) < 60) step = 1;
            if ($urandom_range(0, 99) < 12) begin
                sr_wr = 1; sr_wdata = $urandom() & ~32'h1000_0000;
                if ($urandom_range(0, 3) == 0) sr_wdata = $urandom();
            end
            if ($urandom_range(0, 99) < 4) begin
                vbr_wr = 1; vbr_wdata = $urandom() & 32'hFFFF_F000;
            end
            run_cycle();
        end
        finish_run();
    end
endmodule